// File: doc/BRIEF.md
# Single-Cycle Integer Datapath

This block is the data half of a 32-bit processor core that retires one instruction on every clock. It holds the program counter, the incrementer, the branch target adder, a 32-entry register file, a five-function ALU with a zero flag, the immediate sign extender, and the multiplexers that route operands and results. Instruction words come in from an external instruction memory addressed by the program counter. Loads and stores go through an external data-memory port, addressed by the ALU result.

The block does no decoding of its own. It sends the opcode field, the function field and the ALU zero flag out to a separate controller. That controller returns one set of control lines per cycle, and those lines steer every multiplexer, write enable and ALU function inside the block. Each control line acts only in the cycle in which it is asserted.

Top module: `sc_datapath`

## Requirements
- R1: While `rst_n` is low, `imem_addr` is 0. The first instruction fetched after reset is the one at address 0.
- R2: On each rising clock edge where no branch is taken, the program counter (`imem_addr`) grows by 4.
- R3: When `ctl_branch` is 1 and `alu_zero` is 1, the next program counter is PC+4 plus the sign-extended instruction bits 15:0 shifted left by two. When `ctl_branch` is 1 and `alu_zero` is 0, the program counter advances by 4.
- R4: The register file holds 32 registers of 32 bits. Read port A is addressed by instruction bits 25:21 and read port B by bits 20:16, and both are read in the same cycle. When `ctl_reg_we` is 1, the write takes effect at the rising edge that ends the cycle.
- R5: Register 0 always reads as 0, and a write to register 0 leaves it at 0.
- R6: The write register is instruction bits 15:11 when `ctl_dst_rd` is 1, and bits 20:16 when it is 0.
- R7: The second ALU operand is the sign-extended instruction bits 15:0 when `ctl_imm_sel` is 1, and the read port B value when it is 0.
- R8: The register write data is `dmem_rdata` when `ctl_mem2reg` is 1, and the ALU result when it is 0.
- R9: `ctl_alu_fn` selects the ALU function: 0 = add, 1 = subtract (A minus B), 2 = bitwise AND, 3 = bitwise OR, 4 = set-less-than. Any other code gives a result of 0. `alu_zero` is 1 exactly when the ALU result is 0.
- R10: Set-less-than compares A and B as signed two's-complement numbers and gives the 32-bit value 1 or 0.
- R11: `dmem_addr` is the ALU result and `dmem_wdata` is the read port B value. `dmem_we` follows `ctl_mem_wr` and `dmem_re` follows `ctl_mem_rd`. `opcode` is instruction bits 31:26 and `funct` is bits 5:0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the program counter |
| imem_addr | output | 32 | Instruction fetch address (program counter) |
| imem_data | input | 32 | Instruction word at `imem_addr` |
| dmem_addr | output | 32 | Data-memory address (ALU result) |
| dmem_wdata | output | 32 | Store data (read port B value) |
| dmem_rdata | input | 32 | Load data from data memory |
| dmem_we | output | 1 | Data-memory write strobe |
| dmem_re | output | 1 | Data-memory read strobe |
| ctl_reg_we | input | 1 | Register file write enable |
| ctl_dst_rd | input | 1 | Write-register select: 1 = bits 15:11, 0 = bits 20:16 |
| ctl_imm_sel | input | 1 | Second ALU operand: 1 = immediate, 0 = read port B |
| ctl_mem2reg | input | 1 | Write-back source: 1 = load data, 0 = ALU result |
| ctl_mem_rd | input | 1 | Load request, passed to `dmem_re` |
| ctl_mem_wr | input | 1 | Store request, passed to `dmem_we` |
| ctl_branch | input | 1 | Conditional branch on ALU zero |
| ctl_alu_fn | input | 3 | ALU function code |
| opcode | output | 6 | Instruction bits 31:26 |
| funct | output | 6 | Instruction bits 5:0 |
| alu_zero | output | 1 | ALU result equals 0 |

## Verification
A wrong program counter shows up in the same cycle on `imem_addr` as an unexpected fetch address. After that, every later fetch address is off by the same amount. A corrupted register, a wrong write register or a wrong operand select stays hidden until that register is read by a store, so the bench stores each computed value right after producing it. This exposes such a fault on `dmem_addr`/`dmem_wdata` within one or two instructions. A wrong zero flag or branch target shows on `imem_addr` one edge after the branch instruction, and it also shifts the order of every later store.

// File: rtl/sc_dp_pkg.sv
package sc_dp_pkg;

   typedef enum logic [2:0] {
      ALU_ADD = 3'd0,
      ALU_SUB = 3'd1,
      ALU_AND = 3'd2,
      ALU_OR  = 3'd3,
      ALU_SLT = 3'd4
   } alu_fn_e;

   // instruction field positions decoded by the datapath and the controller
   localparam int INSN_W   = 32;
   localparam int OPC_HI   = 31;
   localparam int OPC_LO   = 26;
   localparam int RSA_HI   = 25;
   localparam int RSA_LO   = 21;
   localparam int RSB_HI   = 20;
   localparam int RSB_LO   = 16;
   localparam int RDS_HI   = 15;
   localparam int RDS_LO   = 11;
   localparam int FUN_HI   = 5;
   localparam int FUN_LO   = 0;
   localparam int IMM_W    = 16;

endpackage

// File: rtl/sc_alu.sv
module sc_alu
   import sc_dp_pkg::*;
#(
   parameter int W          = 32,
   parameter bit SLT_SIGNED = 1'b1
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic [2:0]   fn,
   output logic [W-1:0] y,
   output logic         zero
);

   logic lt;

   generate
      if (SLT_SIGNED) begin : g_slt_s
         assign lt = ($signed(a) < $signed(b));
      end else begin : g_slt_u
         assign lt = (a < b);
      end
   endgenerate

   always_comb begin
      case (alu_fn_e'(fn))
         ALU_ADD: y = a + b;
         ALU_SUB: y = a - b;
         ALU_AND: y = a & b;
         ALU_OR:  y = a | b;
         ALU_SLT: y = {{(W-1){1'b0}}, lt};
         default: y = '0;
      endcase
   end

   assign zero = (y == '0);

   // R9
   always_comb begin
      if (fn == 3'(ALU_SUB)) begin
         sub_zero_chk: assert ((y == '0) == (a == b));
      end
   end

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
   parameter int W       = 32,
   parameter int N       = 32,
   parameter bit ZERO_R0 = 1'b1,
   localparam int AW     = $clog2(N)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] wa,
   input  logic [W-1:0]  wd,
   input  logic [AW-1:0] ra0,
   input  logic [AW-1:0] ra1,
   output logic [W-1:0]  rd0,
   output logic [W-1:0]  rd1
);

   if (N < 2 || (1 << AW) != N) begin : g_bad_n
      $error("sc_regfile: N must be a power of two of at least 2");
   end

   logic [W-1:0] q [N];

   for (genvar i = 0; i < N; i++) begin : g_reg
      if (i == 0 && ZERO_R0) begin : g_hard0
         assign q[i] = '0;
      end else begin : g_store
         logic [W-1:0] r;
         always_ff @(posedge clk) begin
            if (we && wa == AW'(i)) begin
               r <= wd;
            end
         end
         assign q[i] = r;
      end
   end

   assign rd0 = q[ra0];
   assign rd1 = q[ra1];

   // R4
   rf_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (we && wa != '0) |=> (q[$past(wa)] == $past(wd)));

   // R5
   rf_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ZERO_R0 && ra0 == '0) |-> (rd0 == '0));

endmodule

// File: rtl/sc_pc_unit.sv
module sc_pc_unit #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         take,
   input  logic [W-1:0] offset,
   output logic [W-1:0] pc
);

   localparam logic [W-1:0] STEP = W'(4);

   logic [W-1:0] pc_inc;
   logic [W-1:0] target;
   logic [W-1:0] pc_nxt;

   assign pc_inc = pc + STEP;
   assign target = pc_inc + {offset[W-3:0], 2'b00};
   assign pc_nxt = take ? target : pc_inc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc <= '0;
      end else begin
         pc <= pc_nxt;
      end
   end

   // R2
   pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !take |=> (pc == $past(pc) + STEP));

   // R3
   pc_branch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> (pc == $past(pc) + STEP + ($past(offset) << 2)));

endmodule

// File: rtl/sc_datapath.sv
module sc_datapath
   import sc_dp_pkg::*;
#(
   parameter int XLEN       = 32,
   parameter int NREG       = 32,
   parameter bit SLT_SIGNED = 1'b1,
   parameter bit ZERO_R0    = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   output logic [XLEN-1:0] imem_addr,
   input  logic [31:0]     imem_data,
   output logic [XLEN-1:0] dmem_addr,
   output logic [XLEN-1:0] dmem_wdata,
   input  logic [XLEN-1:0] dmem_rdata,
   output logic            dmem_we,
   output logic            dmem_re,
   input  logic            ctl_reg_we,
   input  logic            ctl_dst_rd,
   input  logic            ctl_imm_sel,
   input  logic            ctl_mem2reg,
   input  logic            ctl_mem_rd,
   input  logic            ctl_mem_wr,
   input  logic            ctl_branch,
   input  logic [2:0]      ctl_alu_fn,
   output logic [5:0]      opcode,
   output logic [5:0]      funct,
   output logic            alu_zero
);

   localparam int RAW  = $clog2(NREG);
   localparam int FLDW = RSA_HI - RSA_LO + 1;

   if (RAW != FLDW || (1 << RAW) != NREG) begin : g_bad_nreg
      $error("sc_datapath: NREG must match the 5-bit register fields");
   end
   if (XLEN < IMM_W + 2) begin : g_bad_xlen
      $error("sc_datapath: XLEN too narrow for the immediate");
   end

   logic [RAW-1:0]  ra_a, ra_b, ra_d, wr_sel;
   logic [IMM_W-1:0] imm;
   logic [XLEN-1:0] imm_x, rd_a, rd_b, op_b, alu_y, wb_data;
   logic            zero;

   assign ra_a = imem_data[RSA_HI:RSA_LO];
   assign ra_b = imem_data[RSB_HI:RSB_LO];
   assign ra_d = imem_data[RDS_HI:RDS_LO];
   assign imm  = imem_data[IMM_W-1:0];

   assign opcode = imem_data[OPC_HI:OPC_LO];
   assign funct  = imem_data[FUN_HI:FUN_LO];

   assign imm_x   = {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};
   assign wr_sel  = ctl_dst_rd  ? ra_d       : ra_b;
   assign op_b    = ctl_imm_sel ? imm_x      : rd_b;
   assign wb_data = ctl_mem2reg ? dmem_rdata : alu_y;

   sc_regfile #(
      .W       (XLEN),
      .N       (NREG),
      .ZERO_R0 (ZERO_R0)
   ) u_rf (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (ctl_reg_we),
      .wa    (wr_sel),
      .wd    (wb_data),
      .ra0   (ra_a),
      .ra1   (ra_b),
      .rd0   (rd_a),
      .rd1   (rd_b)
   );

   sc_alu #(
      .W          (XLEN),
      .SLT_SIGNED (SLT_SIGNED)
   ) u_alu (
      .a    (rd_a),
      .b    (op_b),
      .fn   (ctl_alu_fn),
      .y    (alu_y),
      .zero (zero)
   );

   sc_pc_unit #(
      .W (XLEN)
   ) u_pc (
      .clk    (clk),
      .rst_n  (rst_n),
      .take   (ctl_branch & zero),
      .offset (imm_x),
      .pc     (imem_addr)
   );

   assign alu_zero   = zero;
   assign dmem_addr  = alu_y;
   assign dmem_wdata = rd_b;
   assign dmem_we    = ctl_mem_wr;
   assign dmem_re    = ctl_mem_rd;

   // R1
   pc_reset_chk: assert property (@(posedge clk)
      !rst_n |-> (imem_addr == '0));

endmodule

// File: tb/sc_datapath_tb.sv
module sc_datapath_tb;

   localparam int CLK_PERIOD = 10;

   typedef struct {
      logic [31:0] pc;
      bit          zc;
      bit          z;
      string       tag;
   } pc_item_t;

   typedef struct {
      logic [31:0] addr;
      logic [31:0] data;
      string       tag;
   } st_item_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] imem_addr, imem_data, dmem_addr, dmem_wdata, dmem_rdata;
   logic        dmem_we, dmem_re;
   logic        c_we, c_dst, c_imm, c_m2r, c_mrd, c_mwr, c_br;
   logic [2:0]  c_fn;
   logic [5:0]  opcode, funct;
   logic        alu_zero;

   int errors = 0;
   int checks = 0;
   bit mon_en = 1'b0;
   bit done   = 1'b0;

   logic [31:0] imem [64];
   logic [31:0] dmem [64];
   pc_item_t    exp_pc [$];
   st_item_t    exp_st [$];

   always #(CLK_PERIOD/2) clk = ~clk;

   sc_datapath u_dut (
      .clk (clk), .rst_n (rst_n),
      .imem_addr (imem_addr), .imem_data (imem_data),
      .dmem_addr (dmem_addr), .dmem_wdata (dmem_wdata), .dmem_rdata (dmem_rdata),
      .dmem_we (dmem_we), .dmem_re (dmem_re),
      .ctl_reg_we (c_we), .ctl_dst_rd (c_dst), .ctl_imm_sel (c_imm),
      .ctl_mem2reg (c_m2r), .ctl_mem_rd (c_mrd), .ctl_mem_wr (c_mwr),
      .ctl_branch (c_br), .ctl_alu_fn (c_fn),
      .opcode (opcode), .funct (funct), .alu_zero (alu_zero)
   );

   // memories outside the block
   assign imem_data  = (imem_addr[31:8] == '0) ? imem[imem_addr[7:2]] : 32'h0;
   assign dmem_rdata = dmem[dmem_addr[7:2]];
   always @(posedge clk) begin
      if (dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;
   end

   // bench-side controller, driven from opcode/funct (R11)
   localparam logic [5:0] OP_RR = 6'h00, OP_ADDI = 6'h08, OP_LW = 6'h23,
                          OP_SW = 6'h2B, OP_BEQ = 6'h04;
   localparam logic [5:0] FN_ADD = 6'h20, FN_SUB = 6'h22, FN_AND = 6'h24,
                          FN_OR = 6'h25, FN_SLT = 6'h2A;

   always_comb begin
      {c_we, c_dst, c_imm, c_m2r, c_mrd, c_mwr, c_br} = '0;
      c_fn = 3'd0;
      case (opcode)
         OP_RR: begin
            c_we = 1'b1; c_dst = 1'b1;
            case (funct)
               FN_SUB:  c_fn = 3'd1;
               FN_AND:  c_fn = 3'd2;
               FN_OR:   c_fn = 3'd3;
               FN_SLT:  c_fn = 3'd4;
               default: c_fn = 3'd0;
            endcase
         end
         OP_ADDI: begin c_we = 1'b1; c_imm = 1'b1; end
         OP_LW:   begin c_we = 1'b1; c_imm = 1'b1; c_m2r = 1'b1; c_mrd = 1'b1; end
         OP_SW:   begin c_imm = 1'b1; c_mwr = 1'b1; end
         OP_BEQ:  begin c_br = 1'b1; c_fn = 3'd1; end
         default: ;
      endcase
   end

   function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
      return {OP_RR, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
   endfunction

   function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, int imm);
      return {op, 5'(rs), 5'(rt), 16'(imm)};
   endfunction

   task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
      end
   endtask

   task automatic push_pc(logic [31:0] pc, bit zc, bit z, string tag);
      pc_item_t it;
      it.pc = pc; it.zc = zc; it.z = z; it.tag = tag;
      exp_pc.push_back(it);
   endtask

   task automatic push_st(logic [31:0] addr, logic [31:0] data, string tag);
      st_item_t it;
      it.addr = addr; it.data = data; it.tag = tag;
      exp_st.push_back(it);
   endtask

   // monitor: pops the scoreboard queues as the datapath produces results
   always @(negedge clk) begin
      if (mon_en) begin
         if (exp_pc.size() > 0) begin
            pc_item_t e;
            e = exp_pc.pop_front();
            check(imem_addr == e.pc, {e.tag, " pc"}, imem_addr, e.pc);
            if (e.pc[31:8] == '0)
               check(opcode == imem[e.pc[7:2]][31:26], "R11 opcode",
                     32'(opcode), 32'(imem[e.pc[7:2]][31:26]));
            if (e.zc)
               check(alu_zero == e.z, {e.tag, " zero"}, 32'(alu_zero), 32'(e.z));
         end
         if (dmem_we) begin
            if (exp_st.size() == 0) begin
               check(1'b0, "R3 unexpected store", dmem_addr, 32'hFFFF_FFFF);
            end else begin
               st_item_t s;
               s = exp_st.pop_front();
               check(dmem_addr == s.addr, {s.tag, " addr"}, dmem_addr, s.addr);
               check(dmem_wdata == s.data, {s.tag, " data"}, dmem_wdata, s.data);
            end
         end
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 5000);
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      for (int i = 0; i < 64; i++) begin imem[i] = 32'h0; dmem[i] = 32'h0; end
      dmem[25] = 32'h1234_5678;                       // byte address 100
      imem[0]  = enc_i(OP_ADDI, 0, 1, 5);             // r1 = 5
      imem[1]  = enc_i(OP_ADDI, 0, 2, -3);            // r2 = -3 (R7 sign extension)
      imem[2]  = enc_r(1, 2, 3, FN_ADD);              // r3 = 2
      imem[3]  = enc_i(OP_SW, 0, 3, 0);
      imem[4]  = enc_r(2, 1, 4, FN_SUB);              // r4 = -8
      imem[5]  = enc_i(OP_SW, 0, 4, 4);
      imem[6]  = enc_r(1, 2, 5, FN_AND);              // r5 = 5
      imem[7]  = enc_r(1, 2, 6, FN_OR);               // r6 = -3
      imem[8]  = enc_i(OP_SW, 0, 5, 8);
      imem[9]  = enc_i(OP_SW, 0, 6, 12);
      imem[10] = enc_r(2, 1, 7, FN_SLT);              // -3 < 5 -> 1
      imem[11] = enc_r(1, 2, 8, FN_SLT);              // 5 < -3 -> 0
      imem[12] = enc_i(OP_SW, 0, 7, 16);
      imem[13] = enc_i(OP_SW, 0, 8, 20);
      imem[14] = enc_i(OP_ADDI, 0, 0, 7);             // write to r0 ignored
      imem[15] = enc_i(OP_SW, 0, 0, 24);
      imem[16] = enc_i(OP_LW, 0, 9, 100);             // r9 = mem[100]
      imem[17] = enc_i(OP_SW, 0, 9, 28);
      imem[18] = enc_i(OP_BEQ, 1, 2, 5);              // not taken
      imem[19] = enc_i(OP_BEQ, 1, 1, 2);              // taken -> 88
      imem[20] = enc_i(OP_SW, 0, 1, 32);              // skipped
      imem[21] = enc_i(OP_SW, 0, 1, 36);              // skipped
      imem[22] = enc_i(OP_SW, 0, 2, 40);
      imem[23] = enc_i(OP_BEQ, 0, 0, -1);             // branch to itself

      // expected fetch sequence
      for (int p = 0; p <= 68; p += 4) push_pc(32'(p), 1'b0, 1'b0, "R2 step");
      push_pc(32'd72, 1'b1, 1'b0, "R3 beq not taken");
      push_pc(32'd76, 1'b1, 1'b1, "R3 beq taken");
      push_pc(32'd88, 1'b0, 1'b0, "R3 target");
      for (int k = 0; k < 4; k++) push_pc(32'd92, 1'b1, 1'b1, "R3 negative offset");

      // expected stores
      push_st(32'd0,  32'h0000_0002, "R4 R6 add");
      push_st(32'd4,  32'hFFFF_FFF8, "R9 sub");
      push_st(32'd8,  32'h0000_0005, "R9 and");
      push_st(32'd12, 32'hFFFF_FFFD, "R9 or");
      push_st(32'd16, 32'h0000_0001, "R10 slt true");
      push_st(32'd20, 32'h0000_0000, "R10 slt false");
      push_st(32'd24, 32'h0000_0000, "R5 r0 write");
      push_st(32'd28, 32'h1234_5678, "R8 load");
      push_st(32'd40, 32'hFFFF_FFFD, "R11 store");

      repeat (3) @(negedge clk);
      check(imem_addr == 32'h0, "R1 reset pc", imem_addr, 32'h0);
      @(posedge clk);
      #1;
      rst_n  = 1'b1;
      mon_en = 1'b1;
      repeat (32) @(negedge clk);
      #1;
      check(exp_pc.size() == 0, "R2 fetch queue drained", 32'(exp_pc.size()), 32'd0);
      check(exp_st.size() == 0, "R8 store queue drained", 32'(exp_st.size()), 32'd0);
      check(imem_addr == 32'd92, "R3 loop holds", imem_addr, 32'd92);
      finish_run();
   end

endmodule